// File: doc/BRIEF.md
# Command Packet Scatter-Gather Fetcher

This block serves one storage channel. Software first builds a command packet in memory. It then writes a run command word to the channel. The block fetches the packet's 64-byte header area over a word-addressed memory-read port and validates the two block tags and the valid flag. It also captures the direction, interrupt, transfer-mode and extended-LBA flags. After that it walks the scatter-gather table that the packet points to. For each table entry it raises one transfer request carrying that entry's address and length, and it waits for the request to be acknowledged before it reads the next entry.

Memory is seen as 64-bit little-endian words, and a byte address maps to word address `byte_addr >> 3`. The packet base and the table address are assumed to be 8-byte aligned. At the end the block pulses `done` and presents a two-bit status code. The code shows whether the packet was rejected, whether the summed descriptor lengths matched the packet's byte count, or whether the run was clean.

Top module: `pkt_sg_walker`

## Requirements
- R1: A run starts only when `cmd_wr` is high with `cmd_word` equal to 0x107 while `busy` is low. Any other command word, and any command written while `busy` is high, has no effect.
- R2: The header is read from `pkt_base` as four words. Word 0 holds tag byte 0 (must be 0x01), the host flag byte at byte 1 and the total byte count at bytes 4..7. Word 1 holds the descriptor count at bytes 8..11. Word 2 holds the table address at bytes 16..23. Word 3 holds tag byte 24 (must be 0x02) and the device flag byte at byte 28. At most one memory read is outstanding at a time, and `rd_addr` is the byte address shifted right by 3.
- R3: If tag byte 0 is not 0x01, tag byte 24 is not 0x02, or host flag bit 5 (valid) is clear, the run ends with status 1 and no transfer request is raised.
- R4: After the header is read, `dir_out` equals host flag bit 0, `irq_en` equals host flag bit 4, `dma_sel` equals device flag bit 2 and `lba48` equals device flag bit 3.
- R5: For a valid packet with count N, exactly N transfer requests are issued, in table order. Entry i sits at table address + 16*i, with its 64-bit address at entry bytes 0..7 and its 32-bit length at entry bytes 8..11.
- R6: A valid packet with a descriptor count of zero completes without any transfer request.
- R7: At the end of a valid packet, the status is 2 if the sum of the descriptor lengths differs from the total byte count, and 0 otherwise.
- R8: A transfer request stays high with a stable address and length until it is acknowledged. No memory read is issued while a request is pending, and only one read is in flight at a time.
- R9: `done` is a one-cycle pulse that coincides with `busy` low, and `status` holds its value until the next run starts.
- R10: After reset, `busy`, `done`, `rd_en` and `xfer_req` are low, and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word (0x107 starts a run) |
| pkt_base | input | AW | Byte address of the command packet |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW-3 | Memory word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Read data, little-endian |
| xfer_req | output | 1 | Transfer request |
| xfer_addr | output | AW | Transfer buffer address |
| xfer_len | output | 32 | Transfer length in bytes |
| xfer_ack | input | 1 | Transfer acknowledge |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (one cycle) |
| status | output | 2 | 0 ok, 1 rejected packet, 2 length mismatch |
| dir_out | output | 1 | Data direction is toward the device |
| irq_en | output | 1 | Interrupt on completion requested |
| dma_sel | output | 1 | DMA rather than PIO |
| lba48 | output | 1 | Extended 48-bit LBA |

## Verification
The hardest condition to reach from the ports is a transfer request that is held while reads for the next descriptor are still waiting. The stimulus gets there by holding back the acknowledge for zero to two extra cycles. This is swept against descriptor counts from zero to five and against every flag combination, so the hold and the ordering of reads behind acknowledges are both exercised. A second hard case is a run command that arrives mid-run. The bench injects one while the header is still being fetched and then counts `done` pulses. Rejected packets, a table placed away from the header, and totals that are too large or too small are built on purpose, and the expected status is computed from the lengths the bench itself wrote.

// File: rtl/pkt_sg_walker.sv
module pkt_sg_walker #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [31:0]   cmd_word,
  input  logic [AW-1:0] pkt_base,
  output logic          rd_en,
  output logic [AW-4:0] rd_addr,
  input  logic          rd_valid,
  input  logic [63:0]   rd_data,
  output logic          xfer_req,
  output logic [AW-1:0] xfer_addr,
  output logic [31:0]   xfer_len,
  input  logic          xfer_ack,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic          dir_out,
  output logic          irq_en,
  output logic          dma_sel,
  output logic          lba48
);
  localparam int WA = AW - 3;
  localparam logic [31:0] RUN_CMD = 32'h107;
  localparam int SW = 40;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_CHK, S_DESC, S_XFER, S_FIN} st_t;
  st_t st;

  logic [WA-1:0] wptr;
  logic [1:0]    idx;
  logic          pend;
  logic [7:0]    tag0, tag1, hfl, dfl;
  logic [31:0]   total, dcnt, left;
  logic [63:0]   tbl;
  logic [SW-1:0] sum;

  assign busy     = (st != S_IDLE);
  assign xfer_req = (st == S_XFER);
  assign rd_en    = (st == S_HDR || st == S_DESC) && !pend;
  assign rd_addr  = wptr;
  assign dir_out  = hfl[0];
  assign irq_en   = hfl[4];
  assign dma_sel  = dfl[2];
  assign lba48    = dfl[3];

  wire pkt_ok = (tag0 == 8'h01) && (tag1 == 8'h02) && hfl[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wptr <= '0; idx <= '0; pend <= 1'b0;
      tag0 <= '0; tag1 <= '0; hfl <= '0; dfl <= '0;
      total <= '0; dcnt <= '0; left <= '0; tbl <= '0; sum <= '0;
      xfer_addr <= '0; xfer_len <= '0; done <= 1'b0; status <= 2'd0;
    end else begin
      done <= 1'b0;
      if (rd_en) pend <= 1'b1;
      case (st)
        S_IDLE: if (cmd_wr && cmd_word == RUN_CMD) begin
          wptr <= pkt_base[AW-1:3]; idx <= '0; pend <= 1'b0;
          sum <= '0; status <= 2'd0; st <= S_HDR;
        end
        S_HDR: if (rd_valid) begin
          case (idx)
            2'd0: begin tag0 <= rd_data[7:0]; hfl <= rd_data[15:8]; total <= rd_data[63:32]; end
            2'd1: dcnt <= rd_data[31:0];
            2'd2: tbl <= rd_data;
            default: begin tag1 <= rd_data[7:0]; dfl <= rd_data[39:32]; end
          endcase
          pend <= 1'b0; wptr <= wptr + 1'b1; idx <= idx + 1'b1;
          if (idx == 2'd3) st <= S_CHK;
        end
        S_CHK: begin
          idx <= '0;
          if (!pkt_ok) begin
            status <= 2'd1; st <= S_FIN;
          end else if (dcnt == 32'd0) begin
            st <= S_FIN;
          end else begin
            wptr <= tbl[AW-1:3]; left <= dcnt; st <= S_DESC;
          end
        end
        S_DESC: if (rd_valid) begin
          if (idx == 2'd0) xfer_addr <= rd_data[AW-1:0];
          else begin xfer_len <= rd_data[31:0]; st <= S_XFER; end
          pend <= 1'b0; wptr <= wptr + 1'b1; idx <= idx + 1'b1;
        end
        S_XFER: if (xfer_ack) begin
          sum <= sum + SW'(xfer_len); left <= left - 1'b1; idx <= '0;
          st <= (left == 32'd1) ? S_FIN : S_DESC;
        end
        default: begin
          done <= 1'b1;
          if (status != 2'd1) status <= (sum != SW'(total)) ? 2'd2 : 2'd0;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pkt_sg_walker_chk.sv
module pkt_sg_walker_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic [31:0]   cmd_word,
  input logic          rd_en,
  input logic          xfer_req,
  input logic          xfer_ack,
  input logic [AW-1:0] xfer_addr,
  input logic [31:0]   xfer_len,
  input logic          busy,
  input logic          done,
  input logic [1:0]    status
);
  logic [7:0] acks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acks <= '0;
    else if (!busy && cmd_wr && cmd_word == 32'h107) acks <= '0;
    else if (xfer_req && xfer_ack) acks <= acks + 1'b1;
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len));
  assert_no_read_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && xfer_req));
  assert_one_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  assert_reject_no_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 2'd1 |-> acks == 8'd0);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !busy && !(cmd_wr && cmd_word == 32'h107) |=> $stable(status));
  assert_bad_cmd_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(cmd_wr && cmd_word == 32'h107) |=> !busy);
endmodule

bind pkt_sg_walker pkt_sg_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_pkt_sg_walker.sv
module test_pkt_sg_walker;
  localparam int PER = 10;
  localparam int AW = 64;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0;
  logic [31:0] cmd_word = 0;
  logic [AW-1:0] pkt_base = 64'd64;
  logic rd_en, rd_valid = 0;
  logic [AW-4:0] rd_addr;
  logic [63:0] rd_data = 0;
  logic xfer_req, xfer_ack = 0;
  logic [AW-1:0] xfer_addr;
  logic [31:0] xfer_len;
  logic busy, done, dir_out, irq_en, dma_sel, lba48;
  logic [1:0] status;

  always #(PER/2) clk = ~clk;

  pkt_sg_walker #(.AW(AW)) i_pkt_sg_walker (.*);

  logic [63:0] mem [0:255];
  int checks = 0, fails = 0;
  int ack_dly = 0, ack_cnt = 0;
  int ng = 0, ndone = 0, nrd = 0;
  logic [63:0] got_a [0:15];
  logic [31:0] got_l [0:15];

  always @(posedge clk) begin
    rd_valid <= rd_en;
    rd_data  <= mem[rd_addr[7:0]];
    if (rd_en) nrd <= nrd + 1;
    if (done) ndone <= ndone + 1;
    if (xfer_req && xfer_ack) begin
      got_a[ng[3:0]] <= xfer_addr; got_l[ng[3:0]] <= xfer_len; ng <= ng + 1;
    end
    if (xfer_req && !xfer_ack) begin
      if (ack_cnt >= ack_dly) begin xfer_ack <= 1; ack_cnt <= 0; end
      else ack_cnt <= ack_cnt + 1;
    end else xfer_ack <= 0;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1; cmd_word = w;
    @(negedge clk); cmd_wr = 0; cmd_word = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk(0, "watchdog", 0, 1);
  endtask

  task automatic run_pkt(input int n, input logic [7:0] h0, input logic [7:0] hf,
                         input logic [7:0] h1, input logic [7:0] df, input int adj,
                         input int tbl_word, input bit extra_cmd, input string tag);
    longint sum = 0;
    int exp_st, exp_n, d0;
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = 64'hdead_beef_0bad_f00d;
    for (int i = 0; i < n; i++) begin
      mem[tbl_word + 2*i]     = 64'h0000_1000_0000_0000 + 64'(i) * 64'h1_0000 + 64'(n);
      mem[tbl_word + 2*i + 1] = {32'hffff_ffff, 32'(512*(i+1) + n)};
      sum += 512*(i+1) + n;
    end
    mem[8]  = {32'(sum + adj), 16'h5a5a, hf, h0};
    mem[9]  = {32'h7777_7777, 32'(n)};
    mem[10] = 64'(tbl_word) * 8;
    mem[11] = {24'h0, df, 24'h0, h1};
    ok = (h0 == 8'h01) && (h1 == 8'h02) && hf[5];
    exp_st = !ok ? 1 : ((sum + adj) != sum) ? 2 : 0;
    exp_n = ok ? n : 0;
    ng = 0; d0 = ndone;
    send_cmd(32'h107);
    if (extra_cmd) begin
      send_cmd(32'h107);
      chk(busy == 1, {tag, " R1 busy during run"}, busy, 1);
    end
    wait_done();
    chk(busy == 0, {tag, " R9 busy low at done"}, busy, 0);
    @(negedge clk);
    chk(status == 2'(exp_st), {tag, " R3/R7 status"}, status, exp_st);
    chk(ng == exp_n, {tag, " R5/R6 transfer count"}, ng, exp_n);
    if (ok) begin
      chk(dir_out == hf[0] && irq_en == hf[4] && dma_sel == df[2] && lba48 == df[3],
          {tag, " R4 flags"}, {dir_out, irq_en, dma_sel, lba48}, {hf[0], hf[4], df[2], df[3]});
      for (int i = 0; i < exp_n && i < 16; i++) begin
        chk(got_a[i] == mem[tbl_word + 2*i], {tag, " R5 address"}, got_a[i], mem[tbl_word + 2*i]);
        chk(got_l[i] == 32'(512*(i+1) + n), {tag, " R5 length"}, got_l[i], 512*(i+1) + n);
      end
    end
    repeat (4) @(negedge clk);
    chk(ndone == d0 + 1 && !done, {tag, " R9 single done"}, ndone - d0, 1);
    chk(status == 2'(exp_st), {tag, " R9 status held"}, status, exp_st);
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !xfer_req && status == 0, "R10 reset state",
        {busy, done, rd_en, xfer_req, status}, 0);
    rst_n = 1;
    @(negedge clk);
    r0 = nrd;
    send_cmd(32'h106);
    send_cmd(32'h007);
    repeat (5) @(negedge clk);
    chk(!busy && nrd == r0, "R1 wrong command ignored", nrd - r0, 0);
    for (int n = 0; n <= 5; n++)
      for (int d = 0; d <= 2; d++)
        for (int f = 0; f < 4; f++) begin
          ack_dly = d;
          run_pkt(n, 8'h01, 8'h28 | 8'(f & 1) | (f[1] ? 8'h10 : 8'h00), 8'h02,
                  f[1] ? 8'h0c : (f[0] ? 8'h04 : 8'h08), 0, 16, 0, "sweep R2");
        end
    ack_dly = 1;
    r0 = nrd;
    run_pkt(2, 8'h01, 8'h29, 8'h02, 8'h04, 0, 16, 1, "R1 command while busy");
    chk(nrd - r0 == 8, "R2 R8 read count", nrd - r0, 8);
    run_pkt(4, 8'h01, 8'h28, 8'h02, 8'h04, 0, 40, 0, "R5 remote table");
    run_pkt(3, 8'h01, 8'h28, 8'h02, 8'h04, 5, 16, 0, "R7 total too big");
    run_pkt(3, 8'h01, 8'h28, 8'h02, 8'h04, -1, 16, 0, "R7 total too small");
    run_pkt(0, 8'h01, 8'h28, 8'h02, 8'h04, 7, 16, 0, "R6 R7 zero count nonzero total");
    run_pkt(3, 8'h03, 8'h28, 8'h02, 8'h04, 0, 16, 0, "R3 bad first tag");
    run_pkt(3, 8'h01, 8'h28, 8'h00, 8'h04, 0, 16, 0, "R3 bad second tag");
    run_pkt(3, 8'h01, 8'h09, 8'h02, 8'h04, 0, 16, 0, "R3 valid clear");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PER * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule